// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block keeps a small forwarding table for an Ethernet switch and runs maintenance commands on it on behalf of a CPU. Each entry pairs a 60-bit key with a destination field, an address type, a valid bit and a locked bit. The key is a 12-bit VLAN ID followed by a 48-bit MAC address, and the VLAN ID is the most significant part of the key. Software fills a set of staging registers, then starts a command by writing its code together with a start bit. The start bit doubles as a busy flag and clears by itself when the command finishes. The engine then writes its results back into the same staging registers.

All searches walk the table one slot per clock, so the table needs only one read port. Software can learn, remove and look up entries by key, read or write a slot by index, and wipe the table. It can also walk the table in two ways. A slot-order scan starts from an index. A key-order search returns the entry with the smallest key above a given key. That key-order search lets software list the whole table in sorted order, without hashing and without keeping a copy of the table.

Top module: `mact_engine`

## Requirements
- R1: Register 0 (key high) maps bits 27:16 to the VLAN ID, bits 15:8 to MAC byte 0 and bits 7:0 to MAC byte 1, and bits 31:28 read back as 0. Register 1 (key low) maps bits 31:24 down to bits 7:0 to MAC bytes 2 to 5. Keys are ordered with the VLAN ID on top, then MAC byte 0 down to MAC byte 5.
- R2: Register 5 (control) takes a command code in bits 3:1 and starts the command when it is written with bit 0 set. Bit 0 reads 1 from the next cycle until the command ends, which takes at most DEPTH+2 cycles, and then reads 0.
- R3: While a command runs, writes to every register are ignored, including a second command write.
- R4: Learn (code 0) stores the key with the register 2 (entry) fields, where destination is bits 11:0, type is bits 13:12, valid is bit 14 and locked is bit 15, and it forces valid to 1. If the key is already present, that slot is overwritten in place. Otherwise the key goes into the lowest-numbered free slot.
- R5: Learn into a full table with a new key stores nothing and sets the sticky overflow flag, which reads in control bit 8. Only clear-all or reset clears the flag.
- R6: Unlearn (code 1) invalidates the slot that holds the key. A key that is not present leaves the table unchanged.
- R7: Lookup (code 2) on a hit loads the stored destination, type and locked bits into the entry register with valid set. On a miss it clears only the valid bit.
- R8: Read (code 3) loads the key and entry registers, including the valid bit, from the slot that register 3 (index) selects. Write (code 4) stores the key and entry registers into that slot exactly as they are.
- R9: Find-next (code 6) returns the valid entry with the smallest key strictly greater than the key registers. It loads the key, entry and index registers from that entry. If there is no such entry, it clears only the entry valid bit.
- R10: When bit 0 of register 4 (scan config) is set, find-next and scan skip locked entries.
- R11: Scan (code 5) searches upward from the slot in the index register for the first valid entry and loads the key, entry and index registers from it. With scan config bit 1 clear, it examines only that one slot. If nothing is found, it clears only the entry valid bit.
- R12: Clear-all (code 7) invalidates every slot and clears the overflow flag.
- R13: After reset, every register reads 0, the table is empty and no command is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
The bench targets several corner cases:
- Re-learning a key that is already present. A design that appended instead of overwriting in place would leave a stale duplicate that a read by index exposes.
- Learning after a removal. If learn skipped the freed low slot, the new key would land in the wrong place.
- Comparing keys. A design that compared MAC bits before the VLAN would return the wrong key, because the bench places a maximal MAC under VLAN 0 below a small MAC under VLAN 1.
- Searching from the largest key. Find-next must report nothing here.
- Ignoring locked entries, a full table, and a command written while another is running. A mistake in these would surface as a found locked entry, a silently dropped overflow, or a table wiped by an ignored clear.

// File: rtl/mact_pkg.sv
// Package: shared types and field positions for the MAC table command engine.
// Assumes a 12-bit VLAN ID and a 48-bit MAC form the 60-bit key, VLAN on top.
package mact_pkg;

    localparam int VID_W = 12;
    localparam int MAC_W = 48;
    localparam int KEY_W = VID_W + MAC_W;

    // Command codes carried in control bits 3:1.
    typedef enum logic [2:0] {
        CMD_LEARN     = 3'd0,
        CMD_UNLEARN   = 3'd1,
        CMD_LOOKUP    = 3'd2,
        CMD_READ      = 3'd3,
        CMD_WRITE     = 3'd4,
        CMD_SCAN      = 3'd5,
        CMD_FIND_NEXT = 3'd6,
        CMD_CLEAR     = 3'd7
    } mact_cmd_e;

    // Register addresses.
    typedef enum logic [2:0] {
        RA_KEY_HI = 3'd0,
        RA_KEY_LO = 3'd1,
        RA_ENTRY  = 3'd2,
        RA_INDEX  = 3'd3,
        RA_SCAN   = 3'd4,
        RA_CTRL   = 3'd5
    } mact_reg_e;

    // Entry flags; the packed layout matches entry register bits 15:12.
    typedef struct packed {
        logic       lck;
        logic       vld;
        logic [1:0] atype;
    } mact_flags_t;

    localparam int ENT_FLAGS_LSB = 12;
    localparam int CTRL_CMD_LSB  = 1;
    localparam int CTRL_OVF_BIT  = 8;

endpackage

// File: rtl/mact_regs.sv
// Module: CPU-visible staging registers and command launch.
// Holds the key, entry, index and scan-config registers and the sticky
// overflow flag. Host writes are dropped while the sequencer is busy; the
// sequencer loads results only while busy, so the two never collide.
module mact_regs
    import mact_pkg::*;
#(
    parameter int DEST_W = 12,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_waddr,
    input  logic [31:0]       host_wdata,
    input  logic [2:0]        host_raddr,
    output logic [31:0]       host_rdata,
    input  logic              busy,
    input  logic              ld_key,
    input  logic [KEY_W-1:0]  ld_key_val,
    input  logic              ld_ent,
    input  logic [DEST_W-1:0] ld_dest_val,
    input  mact_flags_t       ld_flags_val,
    input  logic              ld_idx,
    input  logic [IDX_W-1:0]  ld_idx_val,
    input  logic              set_ovf,
    input  logic              clr_ovf,
    output logic [KEY_W-1:0]  key_q,
    output logic [DEST_W-1:0] dest_q,
    output mact_flags_t       flags_q,
    output logic [IDX_W-1:0]  index_q,
    output logic              ign_locked_q,
    output logic              until_found_q,
    output logic              ovf_q,
    output logic              launch,
    output mact_cmd_e         launch_cmd
);

    logic host_ok;
    assign host_ok = host_we && !busy;

    // Start a command only on an accepted control write with bit 0 set.
    assign launch     = host_ok && (host_waddr == RA_CTRL) && host_wdata[0];
    assign launch_cmd = mact_cmd_e'(host_wdata[CTRL_CMD_LSB +: 3]);

    // Register state: host writes when idle, sequencer results when busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q         <= '0;
            dest_q        <= '0;
            flags_q       <= '0;
            index_q       <= '0;
            ign_locked_q  <= 1'b0;
            until_found_q <= 1'b0;
            ovf_q         <= 1'b0;
        end else begin
            if (host_ok) begin
                case (host_waddr)
                    RA_KEY_HI: begin
                        key_q[KEY_W-1 -: VID_W] <= host_wdata[16 +: VID_W];
                        key_q[47:32]            <= host_wdata[15:0];
                    end
                    RA_KEY_LO: key_q[31:0] <= host_wdata;
                    RA_ENTRY: begin
                        dest_q  <= host_wdata[DEST_W-1:0];
                        flags_q <= mact_flags_t'(host_wdata[ENT_FLAGS_LSB +: 4]);
                    end
                    RA_INDEX: index_q <= host_wdata[IDX_W-1:0];
                    RA_SCAN: begin
                        ign_locked_q  <= host_wdata[0];
                        until_found_q <= host_wdata[1];
                    end
                    default: ;
                endcase
            end
            if (ld_key) key_q <= ld_key_val;
            if (ld_ent) begin
                dest_q  <= ld_dest_val;
                flags_q <= ld_flags_val;
            end
            if (ld_idx) index_q <= ld_idx_val;
            if (clr_ovf)      ovf_q <= 1'b0;
            else if (set_ovf) ovf_q <= 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        host_rdata = '0;
        case (host_raddr)
            RA_KEY_HI: begin
                host_rdata[16 +: VID_W] = key_q[KEY_W-1 -: VID_W];
                host_rdata[15:0]        = key_q[47:32];
            end
            RA_KEY_LO: host_rdata = key_q[31:0];
            RA_ENTRY: begin
                host_rdata[DEST_W-1:0]            = dest_q;
                host_rdata[ENT_FLAGS_LSB +: 4]    = flags_q;
            end
            RA_INDEX: host_rdata[IDX_W-1:0] = index_q;
            RA_SCAN:  host_rdata[1:0] = {until_found_q, ign_locked_q};
            RA_CTRL: begin
                host_rdata[0]            = busy;
                host_rdata[CTRL_OVF_BIT] = ovf_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mact_table.sv
// Module: entry storage with one write port, one read port and bulk clear.
// Assumes at most one of clr_all and wr_en per cycle; clear wins if both.
// Slots past DEPTH (when DEPTH is not a power of two) read as empty.
module mact_table
    import mact_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DEST_W = 12,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [DEST_W-1:0] wr_dest,
    input  mact_flags_t       wr_flags,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [KEY_W-1:0]  rd_key,
    output logic [DEST_W-1:0] rd_dest,
    output mact_flags_t       rd_flags
);

    logic [KEY_W-1:0]  key_mem  [DEPTH];
    logic [DEST_W-1:0] dest_mem [DEPTH];
    mact_flags_t       flag_mem [DEPTH];

    // Slot update: reset and clear-all drop valid, a write replaces one slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                key_mem[i]  <= '0;
                dest_mem[i] <= '0;
                flag_mem[i] <= '0;
            end else if (clr_all) begin
                flag_mem[i].vld <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                key_mem[i]  <= wr_key;
                dest_mem[i] <= wr_dest;
                flag_mem[i] <= wr_flags;
            end
        end
    end

    // Read port; a bounds check is only needed when the index can overrun.
    generate
        if (DEPTH == (1 << IDX_W)) begin : g_rd_full
            assign rd_key   = key_mem[rd_idx];
            assign rd_dest  = dest_mem[rd_idx];
            assign rd_flags = flag_mem[rd_idx];
        end else begin : g_rd_bounded
            logic in_range;
            assign in_range = rd_idx < IDX_W'(DEPTH);
            assign rd_key   = in_range ? key_mem[rd_idx]  : '0;
            assign rd_dest  = in_range ? dest_mem[rd_idx] : '0;
            assign rd_flags = in_range ? flag_mem[rd_idx] : '0;
        end
    endgenerate

endmodule

// File: rtl/mact_seq.sv
// Module: command sequencer.
// Launch moves it to SWEEP (one slot per cycle) or straight to FINISH for
// index and clear commands; FINISH applies the result in one cycle and
// returns to IDLE. Assumes the staging registers stay frozen while busy.
module mact_seq
    import mact_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DEST_W = 12,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  mact_cmd_e         launch_cmd,
    input  logic [KEY_W-1:0]  key_q,
    input  logic [DEST_W-1:0] dest_q,
    input  mact_flags_t       flags_q,
    input  logic [IDX_W-1:0]  index_q,
    input  logic              ign_locked,
    input  logic              until_found,
    output logic              busy,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [KEY_W-1:0]  t_key,
    input  logic [DEST_W-1:0] t_dest,
    input  mact_flags_t       t_flags,
    output logic              tw_en,
    output logic [IDX_W-1:0]  tw_idx,
    output logic [KEY_W-1:0]  tw_key,
    output logic [DEST_W-1:0] tw_dest,
    output mact_flags_t       tw_flags,
    output logic              tbl_clear,
    output logic              ld_key,
    output logic [KEY_W-1:0]  ld_key_val,
    output logic              ld_ent,
    output logic [DEST_W-1:0] ld_dest_val,
    output mact_flags_t       ld_flags_val,
    output logic              ld_idx,
    output logic [IDX_W-1:0]  ld_idx_val,
    output logic              set_ovf,
    output logic              clr_ovf
);

    typedef enum logic [1:0] {S_IDLE, S_SWEEP, S_FINISH} seq_state_e;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    seq_state_e       state;
    mact_cmd_e        cmd_q;
    logic [IDX_W-1:0] ptr;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [KEY_W-1:0] best_key;
    logic             free_seen;
    logic [IDX_W-1:0] free_idx;

    logic same_key, visible, bigger, closer, take, stop_early, at_end;

    assign busy = (state != S_IDLE);

    // Per-slot evaluation of the entry under the sweep pointer.
    always_comb begin
        same_key = t_flags.vld && (t_key == key_q);
        visible  = t_flags.vld && !(ign_locked && t_flags.lck);
        bigger   = visible && (t_key > key_q);
        closer   = bigger && (!hit || (t_key < best_key));
        case (cmd_q)
            CMD_LEARN, CMD_UNLEARN, CMD_LOOKUP: take = same_key;
            CMD_SCAN:                           take = visible;
            CMD_FIND_NEXT:                      take = closer;
            default:                            take = 1'b0;
        endcase
        stop_early = ((cmd_q != CMD_FIND_NEXT) && take) ||
                     ((cmd_q == CMD_SCAN) && !until_found);
        at_end     = (ptr >= LAST_IDX);
    end

    // Table read address: sweep pointer, then the chosen slot in FINISH.
    always_comb begin
        if (state == S_SWEEP)         rd_idx = ptr;
        else if (cmd_q == CMD_READ)   rd_idx = index_q;
        else                          rd_idx = hit_idx;
    end

    // State, pointer and search bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cmd_q     <= CMD_LEARN;
            ptr       <= '0;
            hit       <= 1'b0;
            hit_idx   <= '0;
            best_key  <= '0;
            free_seen <= 1'b0;
            free_idx  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (launch) begin
                        cmd_q     <= launch_cmd;
                        hit       <= 1'b0;
                        free_seen <= 1'b0;
                        ptr       <= (launch_cmd == CMD_SCAN) ? index_q : '0;
                        if (launch_cmd inside {CMD_READ, CMD_WRITE, CMD_CLEAR})
                            state <= S_FINISH;
                        else
                            state <= S_SWEEP;
                    end
                end
                S_SWEEP: begin
                    if (take) begin
                        hit      <= 1'b1;
                        hit_idx  <= ptr;
                        best_key <= t_key;
                    end
                    if (!t_flags.vld && !free_seen) begin
                        free_seen <= 1'b1;
                        free_idx  <= ptr;
                    end
                    if (stop_early || at_end) state <= S_FINISH;
                    else                      ptr   <= ptr + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Result actions, applied during the single FINISH cycle.
    always_comb begin
        tw_en        = 1'b0;
        tw_idx       = hit_idx;
        tw_key       = key_q;
        tw_dest      = dest_q;
        tw_flags     = flags_q;
        tbl_clear    = 1'b0;
        ld_key       = 1'b0;
        ld_key_val   = t_key;
        ld_ent       = 1'b0;
        ld_dest_val  = t_dest;
        ld_flags_val = t_flags;
        ld_idx       = 1'b0;
        ld_idx_val   = hit_idx;
        set_ovf      = 1'b0;
        clr_ovf      = 1'b0;
        if (state == S_FINISH) begin
            case (cmd_q)
                CMD_LEARN: begin
                    tw_flags.vld = 1'b1;
                    if (hit) begin
                        tw_en = 1'b1;
                    end else if (free_seen) begin
                        tw_en  = 1'b1;
                        tw_idx = free_idx;
                    end else begin
                        set_ovf = 1'b1;
                    end
                end
                CMD_UNLEARN: begin
                    tw_en        = hit;
                    tw_key       = t_key;
                    tw_dest      = t_dest;
                    tw_flags     = t_flags;
                    tw_flags.vld = 1'b0;
                end
                CMD_LOOKUP: begin
                    ld_ent = 1'b1;
                    if (!hit) begin
                        ld_dest_val      = dest_q;
                        ld_flags_val     = flags_q;
                        ld_flags_val.vld = 1'b0;
                    end
                end
                CMD_READ: begin
                    ld_key = 1'b1;
                    ld_ent = 1'b1;
                end
                CMD_WRITE: begin
                    tw_en  = 1'b1;
                    tw_idx = index_q;
                end
                CMD_SCAN, CMD_FIND_NEXT: begin
                    ld_ent = 1'b1;
                    if (hit) begin
                        ld_key = 1'b1;
                        ld_idx = 1'b1;
                    end else begin
                        ld_dest_val      = dest_q;
                        ld_flags_val     = flags_q;
                        ld_flags_val.vld = 1'b0;
                    end
                end
                default: begin
                    tbl_clear = 1'b1;
                    clr_ovf   = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/mact_engine.sv
// Module: top of the MAC table command engine.
// Connects the staging registers, the sequencer and the entry storage.
// Assumes DEPTH >= 2 and DEST_W <= 12 (the destination field width).
module mact_engine
    import mact_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DEST_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [31:0] reg_rdata
);

    localparam int IDX_W = $clog2(DEPTH);

    logic              busy, launch;
    mact_cmd_e         launch_cmd;
    logic [KEY_W-1:0]  key_q;
    logic [DEST_W-1:0] dest_q;
    mact_flags_t       flags_q;
    logic [IDX_W-1:0]  index_q;
    logic              ign_locked_q, until_found_q, ovf_q;
    logic              ld_key, ld_ent, ld_idx, set_ovf, clr_ovf;
    logic [KEY_W-1:0]  ld_key_val;
    logic [DEST_W-1:0] ld_dest_val;
    mact_flags_t       ld_flags_val;
    logic [IDX_W-1:0]  ld_idx_val;
    logic [IDX_W-1:0]  rd_idx, tw_idx;
    logic [KEY_W-1:0]  t_key, tw_key;
    logic [DEST_W-1:0] t_dest, tw_dest;
    mact_flags_t       t_flags, tw_flags;
    logic              tw_en, tbl_clear;

    mact_regs #(.DEST_W(DEST_W), .IDX_W(IDX_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_we       (reg_we),
        .host_waddr    (reg_waddr),
        .host_wdata    (reg_wdata),
        .host_raddr    (reg_raddr),
        .host_rdata    (reg_rdata),
        .busy          (busy),
        .ld_key        (ld_key),
        .ld_key_val    (ld_key_val),
        .ld_ent        (ld_ent),
        .ld_dest_val   (ld_dest_val),
        .ld_flags_val  (ld_flags_val),
        .ld_idx        (ld_idx),
        .ld_idx_val    (ld_idx_val),
        .set_ovf       (set_ovf),
        .clr_ovf       (clr_ovf),
        .key_q         (key_q),
        .dest_q        (dest_q),
        .flags_q       (flags_q),
        .index_q       (index_q),
        .ign_locked_q  (ign_locked_q),
        .until_found_q (until_found_q),
        .ovf_q         (ovf_q),
        .launch        (launch),
        .launch_cmd    (launch_cmd)
    );

    mact_seq #(.DEPTH(DEPTH), .DEST_W(DEST_W), .IDX_W(IDX_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_cmd   (launch_cmd),
        .key_q        (key_q),
        .dest_q       (dest_q),
        .flags_q      (flags_q),
        .index_q      (index_q),
        .ign_locked   (ign_locked_q),
        .until_found  (until_found_q),
        .busy         (busy),
        .rd_idx       (rd_idx),
        .t_key        (t_key),
        .t_dest       (t_dest),
        .t_flags      (t_flags),
        .tw_en        (tw_en),
        .tw_idx       (tw_idx),
        .tw_key       (tw_key),
        .tw_dest      (tw_dest),
        .tw_flags     (tw_flags),
        .tbl_clear    (tbl_clear),
        .ld_key       (ld_key),
        .ld_key_val   (ld_key_val),
        .ld_ent       (ld_ent),
        .ld_dest_val  (ld_dest_val),
        .ld_flags_val (ld_flags_val),
        .ld_idx       (ld_idx),
        .ld_idx_val   (ld_idx_val),
        .set_ovf      (set_ovf),
        .clr_ovf      (clr_ovf)
    );

    mact_table #(.DEPTH(DEPTH), .DEST_W(DEST_W), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (tbl_clear),
        .wr_en    (tw_en),
        .wr_idx   (tw_idx),
        .wr_key   (tw_key),
        .wr_dest  (tw_dest),
        .wr_flags (tw_flags),
        .rd_idx   (rd_idx),
        .rd_key   (t_key),
        .rd_dest  (t_dest),
        .rd_flags (t_flags)
    );

endmodule

// File: rtl/mact_engine_chk.sv
// Module: protocol checker for mact_engine, attached with bind below.
// Assumes a synchronous active-low reset; every property is disabled in reset.
module mact_engine_chk #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6,
    parameter int KEY_W = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             launch,
    input logic             tw_en,
    input logic             tbl_clear,
    input logic             ovf_q,
    input logic [KEY_W-1:0] key_q,
    input logic [IDX_W-1:0] index_q
);

    int unsigned busy_run;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

    assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= DEPTH + 2);

    assert_regs_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(key_q) && $stable(index_q)));

    assert_table_change_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_en || tbl_clear) |-> busy);

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !tbl_clear) |=> ovf_q);

    assert_clear_drops_ovf_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_clear |=> !ovf_q);

endmodule

bind mact_engine mact_engine_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .KEY_W(mact_pkg::KEY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .launch    (launch),
    .tw_en     (tw_en),
    .tbl_clear (tbl_clear),
    .ovf_q     (ovf_q),
    .key_q     (key_q),
    .index_q   (index_q)
);

// File: tb/mact_engine_test.sv
// Bench for mact_engine: a vector table of key commands, then directed tests.
module mact_engine_test;

    localparam int DEPTH = 8;
    localparam logic [2:0] A_KH = 3'd0, A_KL = 3'd1, A_EN = 3'd2,
                           A_IX = 3'd3, A_SC = 3'd4, A_CT = 3'd5;
    localparam logic [2:0] C_LRN = 3'd0, C_UNL = 3'd1, C_LKP = 3'd2, C_RD = 3'd3,
                           C_WR = 3'd4, C_SCN = 3'd5, C_NXT = 3'd6, C_CLR = 3'd7;

    // Row: cmd[94:92] vid[91:80] mac[79:32] entry_in[31:16] entry_expected[15:0]
    localparam int NV = 11;
    localparam logic [94:0] VEC [NV] = '{
        {C_LRN, 12'h001, 48'h001122334455, 16'h8005, 16'h8005},
        {C_LRN, 12'h001, 48'h001122334466, 16'h1003, 16'h1003},
        {C_LRN, 12'h002, 48'h001122334455, 16'h3007, 16'h3007},
        {C_LKP, 12'h001, 48'h001122334455, 16'h0000, 16'hC005},
        {C_LKP, 12'h001, 48'h001122334466, 16'h0000, 16'h5003},
        {C_LKP, 12'h003, 48'h001122334455, 16'h4ABC, 16'h0ABC},
        {C_LRN, 12'h001, 48'h001122334466, 16'h2009, 16'h2009},
        {C_LKP, 12'h001, 48'h001122334466, 16'h0000, 16'h6009},
        {C_UNL, 12'h001, 48'h001122334455, 16'h0000, 16'h0000},
        {C_LKP, 12'h001, 48'h001122334455, 16'h0000, 16'h0000},
        {C_LKP, 12'h002, 48'h001122334455, 16'h0000, 16'h7007}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    int          checks = 0;
    int          failures = 0;
    int          last_cycles = 0;

    always #5 clk = ~clk;

    mact_engine #(.DEPTH(DEPTH), .DEST_W(12)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run(input logic [2:0] cmd);
        logic [31:0] c;
        int n;
        wr(A_CT, {28'd0, cmd, 1'b1});
        n = 1;
        rd(A_CT, c);
        while (c[0] && n < 200) begin
            @(negedge clk);
            n++;
            rd(A_CT, c);
        end
        last_cycles = n;
    endtask

    task automatic set_key(input logic [11:0] vid, input logic [47:0] mac);
        wr(A_KH, {4'd0, vid, mac[47:32]});
        wr(A_KL, mac[31:0]);
    endtask

    task automatic chk_key(input string tag, input logic [11:0] vid, input logic [47:0] mac);
        logic [31:0] v;
        rd(A_KH, v); chk(tag, v, {4'd0, vid, mac[47:32]});
        rd(A_KL, v); chk(tag, v, mac[31:0]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state of every register
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R13 reset register", v, 32'd0);
        end

        // R4 R6 R7: vector table of learn / unlearn / lookup
        for (int i = 0; i < NV; i++) begin
            set_key(VEC[i][91:80], VEC[i][79:32]);
            wr(A_EN, {16'd0, VEC[i][31:16]});
            run(VEC[i][94:92]);
            rd(A_EN, v);
            case (VEC[i][94:92])
                C_LRN:   chk("R4 learn row", v, {16'd0, VEC[i][15:0]});
                C_UNL:   chk("R6 unlearn row", v, {16'd0, VEC[i][15:0]});
                default: chk("R7 lookup row", v, {16'd0, VEC[i][15:0]});
            endcase
        end

        // R4: relearn overwrote slot 1 in place; R8 read by index
        wr(A_IX, 32'd1); run(C_RD);
        chk_key("R4 in-place key", 12'h001, 48'h001122334466);
        rd(A_EN, v); chk("R8 read entry", v, 32'h6009);
        // R4: new key goes to lowest free slot 0
        set_key(12'h005, 48'hAABBCCDDEEFF); wr(A_EN, 32'h0011); run(C_LRN);
        set_key(12'h000, 48'h0); wr(A_IX, 32'd0); run(C_RD);
        chk_key("R4 lowest free slot", 12'h005, 48'hAABBCCDDEEFF);

        // R1: key register packing and unused bits
        wr(A_KH, 32'hF123ABCD); rd(A_KH, v); chk("R1 key high", v, 32'h0123ABCD);
        wr(A_KL, 32'h89ABCDEF); rd(A_KL, v); chk("R1 key low", v, 32'h89ABCDEF);

        // R12: clear-all empties the table
        run(C_CLR);
        set_key(12'h001, 48'h001122334466); wr(A_EN, 32'h0); run(C_LKP);
        rd(A_EN, v); chk("R12 lookup after clear", v, 32'd0);

        // Build A(slot0 locked) B(1) C(2) D(3)
        set_key(12'h001, 48'h10);           wr(A_EN, 32'h8001); run(C_LRN);
        set_key(12'h001, 48'h20);           wr(A_EN, 32'h0002); run(C_LRN);
        set_key(12'h002, 48'h05);           wr(A_EN, 32'h0003); run(C_LRN);
        set_key(12'h000, 48'hFFFFFFFFFFFF); wr(A_EN, 32'h0004); run(C_LRN);

        // R9: key order puts VLAN above MAC
        wr(A_SC, 32'd0);
        set_key(12'h000, 48'h0); run(C_NXT);
        chk_key("R9 smallest key", 12'h000, 48'hFFFFFFFFFFFF);
        rd(A_EN, v); chk("R9 entry", v, 32'h4004);
        rd(A_IX, v); chk("R9 index", v, 32'd3);
        run(C_NXT);
        chk_key("R9 next crosses VLAN", 12'h001, 48'h10);
        rd(A_EN, v); chk("R9 locked entry returned", v, 32'hC001);
        // R10: ignore-locked skips A
        wr(A_SC, 32'd1);
        set_key(12'h000, 48'hFFFFFFFFFFFF); run(C_NXT);
        chk_key("R10 skip locked", 12'h001, 48'h20);
        rd(A_IX, v); chk("R10 index", v, 32'd1);
        // R9: nothing above the largest key
        set_key(12'h002, 48'h05); run(C_NXT);
        rd(A_EN, v); chk("R9 none found", v, 32'h0002);
        chk_key("R9 key kept", 12'h002, 48'h05);

        // R11: slot-order scan
        wr(A_SC, 32'd2); wr(A_IX, 32'd1); run(C_SCN);
        chk_key("R11 scan at index", 12'h001, 48'h20);
        set_key(12'h001, 48'h20); run(C_UNL);
        wr(A_IX, 32'd1); run(C_SCN);
        chk_key("R11 scan continues", 12'h002, 48'h05);
        rd(A_IX, v); chk("R11 scan index", v, 32'd2);
        wr(A_SC, 32'd0); wr(A_IX, 32'd1); run(C_SCN);
        rd(A_EN, v); chk("R11 single slot miss", v[14], 1'b0);
        wr(A_SC, 32'd3); wr(A_IX, 32'd0); run(C_SCN);
        rd(A_IX, v); chk("R10 scan skips locked", v, 32'd2);
        wr(A_SC, 32'd2); wr(A_IX, 32'd0); run(C_SCN);
        rd(A_EN, v); chk("R11 scan finds locked", v, 32'hC001);

        // R8: write at index then read back
        wr(A_IX, 32'd5); set_key(12'h7FF, 48'h0A0B0C0D0E0F);
        wr(A_EN, 32'h4ABC); run(C_WR);
        wr(A_EN, 32'h0); set_key(12'h0, 48'h0); wr(A_IX, 32'd5); run(C_RD);
        chk_key("R8 write-read key", 12'h7FF, 48'h0A0B0C0D0E0F);
        rd(A_EN, v); chk("R8 write-read entry", v, 32'h4ABC);

        // R5: fill free slots 1,4,6,7, then overflow
        for (int k = 1; k <= 4; k++) begin
            set_key(12'h003, 48'(k)); wr(A_EN, 32'h0001); run(C_LRN);
        end
        rd(A_CT, v); chk("R5 no overflow when fits", v, 32'd0);
        set_key(12'h003, 48'd5); run(C_LRN);
        rd(A_CT, v); chk("R5 overflow flag", v, 32'h100);
        run(C_LKP); rd(A_EN, v); chk("R5 not inserted", v, 32'h0001);
        set_key(12'h003, 48'd1); run(C_LKP);
        rd(A_EN, v); chk("R5 existing still hits", v, 32'h4001);
        rd(A_CT, v); chk("R5 flag sticky", v, 32'h100);
        run(C_CLR);
        rd(A_CT, v); chk("R12 clear drops overflow", v, 32'd0);

        // R2 R3: busy flag and writes ignored while running
        set_key(12'h001, 48'h10); wr(A_EN, 32'h0001); run(C_LRN);
        chk("R2 completion bound", 32'(last_cycles <= DEPTH + 2), 32'd1);
        set_key(12'h009, 48'h99); wr(A_EN, 32'h0);
        wr(A_CT, {28'd0, C_LKP, 1'b1});
        wr(A_CT, {28'd0, C_CLR, 1'b1});
        wr(A_KH, 32'h0FFFFFFF);
        rd(A_CT, v); chk("R2 busy while running", v[0], 1'b1);
        repeat (DEPTH + 2) @(negedge clk);
        rd(A_CT, v); chk("R2 busy cleared", v[0], 1'b0);
        rd(A_KH, v); chk("R3 key write ignored", v, 32'h00090000);
        set_key(12'h001, 48'h10); run(C_LKP);
        rd(A_EN, v); chk("R3 clear command ignored", v, 32'h4001);

        // R13: reset empties the table
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        set_key(12'h001, 48'h10); run(C_LKP);
        rd(A_EN, v); chk("R13 table empty after reset", v, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule